// File: doc/BRIEF.md
# Bridge Write Burst Disconnect Controller

This block sits on the target side of a bridge between two parallel buses. It decides, for each write data phase offered by an initiator, whether the bridge takes the word, takes it and ends the burst with a target disconnect, refuses it without taking it, or answers the whole transaction with a target retry. The decision depends on four things: the kind of write, where the next DWORD address lands, the programmed cache line size and a line-disconnect mode bit, and how much room is left in the posted write buffer and the delayed-transaction queue.

A transaction opens with a one-cycle `start_i` while `frame_i` is high. At that point the controller latches the write kind, the fast back-to-back flag and the direction. Each cycle with `dphase_i` high is one data phase, and the decision for it appears combinationally in that same cycle. After a disconnect or a retry the controller ignores further data phases. When `frame_i` goes low it returns to idle.

Top module: `wrdisc_ctrl`

## Requirements
- R1: When no transaction is open, or while the start cycle has no data phase, accept_o, disconnect_o, retry_o and push_o stay low. This includes reset.
- R2: push_o equals accept_o in every cycle, and accept_o and retry_o are never high together. disconnect_o without accept_o happens only on a later posted phase that finds buf_free_i equal to 0.
- R3: A delayed write (kind_i 2'b00, with 2'b11 handled the same way) is accepted for one data phase only, and disconnect_o is raised on that phase.
- R4: A delayed write whose first data phase sees dq_free_i equal to 0 gets retry_o, and nothing is accepted.
- R5: A posted memory write (kind_i 2'b01) with line_disc_i low is disconnected on the accepted phase whose next DWORD address has its low log2(PAGE_DW) bits all zero, which is a 4 KB crossing at the default.
- R6: A posted memory write with line_disc_i high and a legal cls_i (1, 2, 4, 8 or 16 DWORDs) is disconnected on the accepted phase whose next DWORD address is a multiple of cls_i.
- R7: When cls_i is illegal, a memory write and invalidate (kind_i 2'b10), and also a posted write with line_disc_i high, is disconnected only at the page boundary of R5.
- R8: A memory write and invalidate with a legal cls_i is disconnected at a line boundary only when buf_free_i minus one is smaller than cls_i. Otherwise the burst runs on through the boundary.
- R9: A posted phase with buf_free_i equal to 1 is accepted and disconnected. A first posted phase with buf_free_i equal to 0 gets retry_o.
- R10: A fast back-to-back transaction (fbb_req_i high at start) needs an enable bit. The bit is fbb_en_cmd_i when dir_up_i was high at start and fbb_en_bctl_i otherwise. If that bit is low, or if the first phase cannot be buffered, the answer is retry_o.
- R11: After a disconnect or a retry, further data phases produce no strobe until frame_i goes low. Once frame_i is low, a new start_i is needed before anything is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Initiator holds a transaction open |
| start_i | input | 1 | Address-phase pulse that opens a transaction |
| kind_i | input | 2 | Write kind: 00 delayed, 01 posted, 10 write-and-invalidate, 11 as delayed |
| fbb_req_i | input | 1 | Transaction follows the previous one back-to-back |
| dir_up_i | input | 1 | 1 upstream, 0 downstream |
| dphase_i | input | 1 | Data phase offered this cycle |
| addr_i | input | ADDR_W | Current DWORD address |
| cls_i | input | CLS_W | Cache line size in DWORDs |
| line_disc_i | input | 1 | Posted writes stop at line boundaries |
| buf_free_i | input | BUF_W | Free DWORDs in the posted write buffer |
| dq_free_i | input | DQ_W | Free delayed-transaction queue entries |
| fbb_en_cmd_i | input | 1 | Back-to-back enable for upstream traffic |
| fbb_en_bctl_i | input | 1 | Back-to-back enable for downstream traffic |
| accept_o | output | 1 | Data phase taken |
| disconnect_o | output | 1 | Burst ends at this phase |
| retry_o | output | 1 | Transaction refused, retry later |
| push_o | output | 1 | Write the word into the buffer |

## Verification
The bench places bursts one DWORD before page and line boundaries. A design that tested the current address in place of the next one would disconnect a word late. For write-and-invalidate it sweeps free space across the one-line threshold, where an off-by-one in the room comparison would either cut bursts short or run them past the boundary. It also offers odd line sizes such as 3, 6 and 32, which must fall back to the page rule instead of being treated as power-of-two masks. Finally it sends data phases after a disconnect or a retry and fast back-to-back writes in both directions, so a controller that kept accepting, or that read the wrong enable bit, shows it at the strobes.

// File: rtl/wrdisc_pkg.sv
package wrdisc_pkg;
   typedef enum logic [1:0] {
      WK_DELAYED = 2'b00,
      WK_POSTED  = 2'b01,
      WK_INVAL   = 2'b10,
      WK_RSVD    = 2'b11
   } wkind_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_FIRST = 2'b01,
      ST_XFER  = 2'b10,
      ST_DONE  = 2'b11
   } wst_t;

   typedef struct packed {
      logic accept;
      logic disc;
      logic retry;
   } wdec_t;
endpackage

// File: rtl/wrdisc_bound.sv
// Boundary detectors for the DWORD address that follows the current one.
module wrdisc_bound #(
   parameter int ADDR_W   = 30,
   parameter int PAGE_DW  = 1024,
   parameter int CLS_W    = 8,
   parameter int MAX_LINE = 16
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CLS_W-1:0]  cls_i,
   output logic              page_hit_o,
   output logic              line_hit_o,
   output logic              cls_ok_o
);
   localparam int PAGE_LG    = $clog2(PAGE_DW);
   localparam int LINE_STEPS = $clog2(MAX_LINE) + 1;

   if (PAGE_LG > ADDR_W || PAGE_LG < 1) begin : g_bad_page
      $error("wrdisc_bound: PAGE_DW does not fit ADDR_W");
   end
   if ((1 << PAGE_LG) != PAGE_DW) begin : g_bad_pow
      $error("wrdisc_bound: PAGE_DW must be a power of two");
   end
   if (CLS_W > ADDR_W) begin : g_bad_cls
      $error("wrdisc_bound: CLS_W wider than ADDR_W");
   end
   if (MAX_LINE >= (1 << CLS_W)) begin : g_bad_line
      $error("wrdisc_bound: MAX_LINE does not fit CLS_W");
   end

   logic [ADDR_W-1:0] nxt;
   logic [CLS_W-1:0]  mask;
   logic [LINE_STEPS-1:0] size_match;

   assign nxt  = addr_i + ADDR_W'(1);
   assign mask = cls_i - CLS_W'(1);

   assign page_hit_o = (nxt[PAGE_LG-1:0] == '0);
   assign line_hit_o = ((nxt[CLS_W-1:0] & mask) == '0);

   for (genvar k = 0; k < LINE_STEPS; k++) begin : g_size
      assign size_match[k] = (cls_i == CLS_W'(1 << k));
   end

   assign cls_ok_o = |size_match;
endmodule

// File: rtl/wrdisc_rules.sv
// Per-phase decision: accept, disconnect, retry.
module wrdisc_rules
   import wrdisc_pkg::*;
#(
   parameter int BUF_W = 8,
   parameter int DQ_W  = 3,
   parameter int CLS_W = 8
) (
   input  logic             active_i,
   input  logic             first_i,
   input  logic             dphase_i,
   input  wkind_t           kind_i,
   input  logic             fbb_req_i,
   input  logic             fbb_en_i,
   input  logic [BUF_W-1:0] buf_free_i,
   input  logic [DQ_W-1:0]  dq_free_i,
   input  logic [CLS_W-1:0] cls_i,
   input  logic             line_disc_i,
   input  logic             page_hit_i,
   input  logic             line_hit_i,
   input  logic             cls_ok_i,
   output wdec_t            dec_o
);
   localparam int CMP_W = ((BUF_W > CLS_W) ? BUF_W : CLS_W) + 1;

   logic is_dly;
   logic can_take;
   logic fbb_ok;
   logic last_dw;
   logic short_line;
   logic bound;

   assign is_dly     = (kind_i == WK_DELAYED) || (kind_i == WK_RSVD);
   assign can_take   = is_dly ? (dq_free_i != '0) : (buf_free_i != '0);
   assign fbb_ok     = !fbb_req_i || fbb_en_i;
   assign last_dw    = (buf_free_i == BUF_W'(1));
   assign short_line = (CMP_W'(buf_free_i) - CMP_W'(1)) < CMP_W'(cls_i);

   always_comb begin
      unique case (kind_i)
         WK_POSTED: bound = (line_disc_i && cls_ok_i) ? line_hit_i : page_hit_i;
         WK_INVAL:  bound = cls_ok_i ? (line_hit_i && short_line) : page_hit_i;
         default:   bound = 1'b1;
      endcase
   end

   always_comb begin
      dec_o = '0;
      if (active_i && dphase_i) begin
         if (first_i && (!can_take || !fbb_ok)) begin
            dec_o.retry = 1'b1;
         end else if (!can_take) begin
            dec_o.disc = 1'b1;
         end else begin
            dec_o.accept = 1'b1;
            dec_o.disc   = is_dly || last_dw || bound;
         end
      end
   end
endmodule

// File: rtl/wrdisc_fsm.sv
// Transaction state and attributes latched at the address phase.
module wrdisc_fsm
   import wrdisc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   frame_i,
   input  logic   start_i,
   input  wkind_t kind_i,
   input  logic   fbb_req_i,
   input  logic   dir_up_i,
   input  wdec_t  dec_i,
   output wst_t   st_o,
   output wkind_t kind_o,
   output logic   fbb_req_o,
   output logic   dir_up_o
);
   wst_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!frame_i) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:  if (start_i) st_d = ST_FIRST;
            ST_FIRST,
            ST_XFER: begin
               if (dec_i.retry || dec_i.disc) st_d = ST_DONE;
               else if (dec_i.accept)         st_d = ST_XFER;
            end
            default:  st_d = ST_DONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         kind_o    <= WK_DELAYED;
         fbb_req_o <= 1'b0;
         dir_up_o  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && start_i && frame_i) begin
            kind_o    <= kind_i;
            fbb_req_o <= fbb_req_i;
            dir_up_o  <= dir_up_i;
         end
      end
   end

   assign st_o = st_q;
endmodule

// File: rtl/wrdisc_ctrl.sv
module wrdisc_ctrl
   import wrdisc_pkg::*;
#(
   parameter int ADDR_W   = 30,
   parameter int PAGE_DW  = 1024,
   parameter int CLS_W    = 8,
   parameter int MAX_LINE = 16,
   parameter int BUF_W    = 8,
   parameter int DQ_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_i,
   input  logic              start_i,
   input  logic [1:0]        kind_i,
   input  logic              fbb_req_i,
   input  logic              dir_up_i,
   input  logic              dphase_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CLS_W-1:0]  cls_i,
   input  logic              line_disc_i,
   input  logic [BUF_W-1:0]  buf_free_i,
   input  logic [DQ_W-1:0]   dq_free_i,
   input  logic              fbb_en_cmd_i,
   input  logic              fbb_en_bctl_i,
   output logic              accept_o,
   output logic              disconnect_o,
   output logic              retry_o,
   output logic              push_o
);
   if (BUF_W < 1 || DQ_W < 1) begin : g_bad_cnt
      $error("wrdisc_ctrl: counter widths must be positive");
   end

   wst_t   st;
   wkind_t kind_q;
   logic   fbb_q, dir_q;
   logic   page_hit, line_hit, cls_ok;
   wdec_t  dec;
   logic   active, first, fbb_en;

   wrdisc_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_i  (frame_i),
      .start_i  (start_i),
      .kind_i   (wkind_t'(kind_i)),
      .fbb_req_i(fbb_req_i),
      .dir_up_i (dir_up_i),
      .dec_i    (dec),
      .st_o     (st),
      .kind_o   (kind_q),
      .fbb_req_o(fbb_q),
      .dir_up_o (dir_q)
   );

   wrdisc_bound #(
      .ADDR_W  (ADDR_W),
      .PAGE_DW (PAGE_DW),
      .CLS_W   (CLS_W),
      .MAX_LINE(MAX_LINE)
   ) u_bound (
      .addr_i    (addr_i),
      .cls_i     (cls_i),
      .page_hit_o(page_hit),
      .line_hit_o(line_hit),
      .cls_ok_o  (cls_ok)
   );

   assign active = (st == ST_FIRST) || (st == ST_XFER);
   assign first  = (st == ST_FIRST);
   assign fbb_en = dir_q ? fbb_en_cmd_i : fbb_en_bctl_i;

   wrdisc_rules #(
      .BUF_W(BUF_W),
      .DQ_W (DQ_W),
      .CLS_W(CLS_W)
   ) u_rules (
      .active_i   (active),
      .first_i    (first),
      .dphase_i   (dphase_i),
      .kind_i     (kind_q),
      .fbb_req_i  (fbb_q),
      .fbb_en_i   (fbb_en),
      .buf_free_i (buf_free_i),
      .dq_free_i  (dq_free_i),
      .cls_i      (cls_i),
      .line_disc_i(line_disc_i),
      .page_hit_i (page_hit),
      .line_hit_i (line_hit),
      .cls_ok_i   (cls_ok),
      .dec_o      (dec)
   );

   assign accept_o     = dec.accept;
   assign disconnect_o = dec.disc;
   assign retry_o      = dec.retry;
   assign push_o       = dec.accept;
endmodule

// File: rtl/wrdisc_ctrl_chk.sv
module wrdisc_ctrl_chk
   import wrdisc_pkg::*;
#(
   parameter int BUF_W = 8,
   parameter int DQ_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [BUF_W-1:0] buf_free_i,
   input logic [DQ_W-1:0]  dq_free_i,
   input logic             accept_o,
   input logic             disconnect_o,
   input logic             retry_o,
   input logic             push_o,
   input wst_t             st,
   input wkind_t           kind_q
);
   logic is_dly;
   assign is_dly = (kind_q == WK_DELAYED) || (kind_q == WK_RSVD);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !(accept_o || disconnect_o || retry_o || push_o));

   a_r2_accept_retry_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({accept_o, retry_o}));

   a_r2_nodata_disc: assert property (@(posedge clk) disable iff (!rst_n)
      (disconnect_o && !accept_o) |-> (buf_free_i == '0 && st == ST_XFER));

   a_r3_delayed_single: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o && is_dly) |-> disconnect_o);

   a_r4_delayed_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o && is_dly) |-> (dq_free_i != '0));

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o && !is_dly) |-> (buf_free_i != '0));

   a_r11_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      (disconnect_o || retry_o) |=> !(accept_o || disconnect_o || retry_o));
endmodule

bind wrdisc_ctrl wrdisc_ctrl_chk #(
   .BUF_W(BUF_W),
   .DQ_W (DQ_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .buf_free_i  (buf_free_i),
   .dq_free_i   (dq_free_i),
   .accept_o    (accept_o),
   .disconnect_o(disconnect_o),
   .retry_o     (retry_o),
   .push_o      (push_o),
   .st          (st),
   .kind_q      (kind_q)
);

// File: tb/tb_wrdisc_ctrl.sv
`timescale 1ns/1ps
module tb_wrdisc_ctrl;
   localparam int ADDR_W = 30;
   localparam int CLS_W  = 8;
   localparam int BUF_W  = 8;
   localparam int DQ_W   = 3;
   localparam int PAGE   = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_i = 1'b0, start_i = 1'b0, fbb_req_i = 1'b0, dir_up_i = 1'b0;
   logic [1:0] kind_i = 2'b00;
   logic dphase_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [CLS_W-1:0]  cls_i = 8'd8;
   logic line_disc_i = 1'b0;
   logic [BUF_W-1:0]  buf_free_i = '0;
   logic [DQ_W-1:0]   dq_free_i = '0;
   logic fbb_en_cmd_i = 1'b1, fbb_en_bctl_i = 1'b1;
   logic accept_o, disconnect_o, retry_o, push_o;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   // bench model state: 0 idle, 1 first, 2 xfer, 3 done
   int m_st = 0;
   int m_kind = 0;
   bit m_fbb = 0, m_dir = 0;

   always #2.5 clk = ~clk;

   wrdisc_ctrl dut (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .start_i(start_i),
      .kind_i(kind_i), .fbb_req_i(fbb_req_i), .dir_up_i(dir_up_i),
      .dphase_i(dphase_i), .addr_i(addr_i), .cls_i(cls_i),
      .line_disc_i(line_disc_i), .buf_free_i(buf_free_i), .dq_free_i(dq_free_i),
      .fbb_en_cmd_i(fbb_en_cmd_i), .fbb_en_bctl_i(fbb_en_bctl_i),
      .accept_o(accept_o), .disconnect_o(disconnect_o), .retry_o(retry_o),
      .push_o(push_o)
   );

   task automatic chk(bit ok, string tag, logic [3:0] got, logic [3:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual={push,acc,disc,retry}=%b expected=%b t=%0t", tag, got, exp, $time);
      end
   endtask

   function automatic bit legal_cls(int c);
      return (c == 1 || c == 2 || c == 4 || c == 8 || c == 16);
   endfunction

   // expected {accept, disc, retry} from the requirements
   function automatic logic [2:0] model(int addr, int bfree, int dq, int cls, bit mode,
                                        bit encmd, bit enbc, output string tag);
      bit dly, can, fok, page, line, bnd, lg;
      int nxt;
      dly  = (m_kind == 0 || m_kind == 3);
      nxt  = addr + 1;
      lg   = legal_cls(cls);
      page = (nxt % PAGE) == 0;
      line = lg && ((nxt % cls) == 0);
      can  = dly ? (dq != 0) : (bfree != 0);
      fok  = !m_fbb || (m_dir ? encmd : enbc);
      tag  = "R1";
      if (!(m_st == 1 || m_st == 2) || !dphase_i) begin
         tag = (m_st == 3) ? "R11" : "R1";
         return 3'b000;
      end
      if (m_st == 1 && (!can || !fok)) begin
         tag = !fok ? "R10" : (dly ? "R4" : "R9");
         return 3'b001;
      end
      if (!can) begin tag = "R2"; return 3'b010; end
      if (dly) begin tag = "R3"; return 3'b110; end
      if (m_kind == 1) begin
         if (mode && lg) begin tag = "R6"; bnd = line; end
         else begin tag = mode ? "R7" : "R5"; bnd = page; end
      end else begin
         if (lg) begin tag = "R8"; bnd = line && ((bfree - 1) < cls); end
         else begin tag = "R7"; bnd = page; end
      end
      if (bfree == 1) tag = "R9";
      return {1'b1, bnd || (bfree == 1), 1'b0};
   endfunction

   task automatic model_edge(logic [2:0] d);
      if (!frame_i) m_st = 0;
      else if (m_st == 0) begin
         if (start_i) begin
            m_st = 1; m_kind = int'(kind_i); m_fbb = fbb_req_i; m_dir = dir_up_i;
         end
      end else if (m_st == 1 || m_st == 2) begin
         if (d[0] || d[1]) m_st = 3;
         else if (d[2]) m_st = 2;
      end
   endtask

   task automatic open_txn(int kind, bit fbb, bit dir);
      logic [3:0] g;
      @(negedge clk);
      frame_i = 1; start_i = 1; dphase_i = 0;
      kind_i = 2'(kind); fbb_req_i = fbb; dir_up_i = dir;
      #1;
      g = {push_o, accept_o, disconnect_o, retry_o};
      chk(g == 4'b0000, "R1", g, 4'b0000);
      @(posedge clk);
      model_edge(3'b000);
      @(negedge clk);
      start_i = 0;
   endtask

   task automatic close_txn();
      @(negedge clk);
      frame_i = 0; dphase_i = 0;
      @(posedge clk);
      model_edge(3'b000);
   endtask

   task automatic phase(int addr, int bfree, int dq, int cls, bit mode,
                        bit encmd, bit enbc, output logic [2:0] got);
      logic [2:0] e;
      logic [3:0] g;
      string tag;
      @(negedge clk);
      dphase_i = 1; addr_i = ADDR_W'(addr); buf_free_i = BUF_W'(bfree);
      dq_free_i = DQ_W'(dq); cls_i = CLS_W'(cls); line_disc_i = mode;
      fbb_en_cmd_i = encmd; fbb_en_bctl_i = enbc;
      #1;
      e = model(addr, bfree, dq, cls, mode, encmd, enbc, tag);
      g = {push_o, accept_o, disconnect_o, retry_o};
      got = g[2:0];
      chk(g == {e[2], e}, tag, g, {e[2], e});
      @(posedge clk);
      model_edge(e);
   endtask

   // one directed phase with an explicit expectation
   task automatic dphase(int addr, int bfree, int dq, int cls, bit mode,
                         logic [2:0] want, string tag);
      logic [2:0] got;
      phase(addr, bfree, dq, cls, mode, fbb_en_cmd_i, fbb_en_bctl_i, got);
      chk(got == want, tag, {got[2], got}, {want[2], want});
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         fails++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [2:0] got;
      int cls_set[9] = '{0, 1, 2, 3, 4, 6, 8, 16, 32};
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      chk({push_o, accept_o, disconnect_o, retry_o} == 4'b0, "R1",
          {push_o, accept_o, disconnect_o, retry_o}, 4'b0);
      rst_n = 1;
      // R1: data phase with no open transaction
      frame_i = 1;
      dphase(5, 20, 2, 8, 0, 3'b000, "R1");
      close_txn();

      // R3 delayed single phase, then R11 quiet afterwards
      open_txn(0, 0, 0);
      dphase(100, 20, 2, 8, 0, 3'b110, "R3");
      dphase(101, 20, 2, 8, 0, 3'b000, "R11");
      close_txn();
      // R11: no start -> nothing
      @(negedge clk); frame_i = 1;
      dphase(200, 20, 2, 8, 0, 3'b000, "R11");
      close_txn();

      // R4 delayed with full queue
      open_txn(0, 0, 0);
      dphase(100, 20, 0, 8, 0, 3'b001, "R4");
      close_txn();

      // R5 posted page rule
      open_txn(1, 0, 0);
      dphase(1022, 30, 2, 8, 0, 3'b100, "R5");
      dphase(1023, 29, 2, 8, 0, 3'b110, "R5");
      close_txn();

      // R6 line rule in line mode
      open_txn(1, 0, 0);
      dphase(5, 30, 2, 8, 1, 3'b100, "R6");
      dphase(6, 29, 2, 8, 1, 3'b100, "R6");
      dphase(7, 28, 2, 8, 1, 3'b110, "R6");
      close_txn();

      // R7 illegal sizes fall back to the page rule
      open_txn(2, 0, 0);
      dphase(7, 3, 2, 6, 0, 3'b100, "R7");
      close_txn();
      open_txn(1, 0, 0);
      dphase(2, 30, 2, 3, 1, 3'b100, "R7");
      dphase(2047, 30, 2, 3, 1, 3'b110, "R7");
      close_txn();

      // R8 write-and-invalidate room threshold
      open_txn(2, 0, 0);
      dphase(3, 5, 2, 4, 0, 3'b100, "R8");
      dphase(7, 4, 2, 4, 0, 3'b110, "R8");
      close_txn();
      open_txn(2, 0, 0);
      dphase(1023, 30, 2, 32, 0, 3'b110, "R7");
      close_txn();

      // R9 buffer limits
      open_txn(1, 0, 0);
      dphase(40, 1, 2, 8, 0, 3'b110, "R9");
      close_txn();
      open_txn(1, 0, 0);
      dphase(40, 0, 2, 8, 0, 3'b001, "R9");
      close_txn();
      open_txn(2, 0, 0);
      dphase(40, 9, 2, 16, 0, 3'b100, "R2");
      dphase(41, 0, 2, 16, 0, 3'b010, "R2");
      close_txn();

      // R10 back-to-back enables by direction
      fbb_en_cmd_i = 0; fbb_en_bctl_i = 1;
      open_txn(1, 1, 1);
      dphase(40, 9, 2, 16, 0, 3'b001, "R10");
      close_txn();
      open_txn(1, 1, 0);
      dphase(40, 9, 2, 16, 0, 3'b100, "R10");
      close_txn();
      fbb_en_cmd_i = 1; fbb_en_bctl_i = 0;
      open_txn(1, 1, 1);
      dphase(40, 0, 2, 16, 0, 3'b001, "R10");
      close_txn();
      open_txn(0, 1, 0);
      dphase(40, 9, 2, 16, 0, 3'b001, "R10");
      close_txn();

      // constrained random bursts, checked against the bench model
      for (int t = 0; t < 300; t++) begin
         int kind, addr, bfree, dq, cls, nph;
         bit mode, ec, eb;
         kind  = $urandom_range(0, 3);
         addr  = $urandom_range(0, 7) * PAGE +
                 (($urandom_range(0, 1) == 1) ? (PAGE - 1 - $urandom_range(0, 19))
                                               : $urandom_range(0, 39));
         bfree = $urandom_range(0, 24);
         dq    = $urandom_range(0, 3);
         cls   = cls_set[$urandom_range(0, 8)];
         mode  = $urandom_range(0, 1);
         ec    = ($urandom_range(0, 3) != 0);
         eb    = ($urandom_range(0, 3) != 0);
         nph   = $urandom_range(1, 24);
         open_txn(kind, ($urandom_range(0, 7) == 0), $urandom_range(0, 1));
         for (int p = 0; p < nph; p++) begin
            phase(addr, bfree, dq, cls, mode, ec, eb, got);
            if (got[2]) begin
               addr++;
               if (bfree > 0) bfree--;
            end
            if (m_st == 3 || m_st == 0) break;
         end
         close_txn();
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule